// File: doc/BRIEF.md
# Sequential Significand Divider for Double-Precision Operands

This block takes two 64-bit binary64 operands and divides the significand of the first by the significand of the second, one quotient bit per clock. It uses a restoring compare-and-subtract loop. Alongside the quotient it returns the true remainder, a sticky bit (the OR of the remainder bits), the unbiased-then-rebiased exponent difference and the result sign. A later stage is expected to normalize the quotient and round it. That stage, and all exception signalling apart from a zero divisor, are outside this block.

Operands arrive on a valid/ready input channel, and results leave on a valid/ready output channel. Only one division is in flight at a time. `in_ready` is high only while the block is idle. Once a result is presented on the output, it stays there unchanged until `out_ready` is seen high. No new operands are taken until that output handshake has completed. A divisor whose significand is zero bypasses the loop and is reported with a flag.

Top module: `dsig_divider`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 exactly while the block is idle. A transfer takes place on a rising edge where both `in_valid` and `in_ready` are 1.
- R2: For a nonzero divisor significand, `out_valid` goes to 1 exactly Q_W clock edges after the accepting edge (Q_W = 56 by default).
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and every result output keep their values. The edge on which `out_valid` and `out_ready` are both 1 returns the block to idle, so `in_ready` is 1 in the next cycle.
- R4: An operand whose 11-bit exponent field (bits 62:52) is nonzero has significand 1.f and effective exponent equal to the field; all-ones exponents are treated the same way. An operand with a zero exponent field and nonzero fraction has no hidden bit. Its fraction is shifted left by n until bit 52 is set, and its effective exponent is 1 - n.
- R5: `quot` equals floor(SA * 2^(Q_W-1) / SB), where SA and SB are the R4 significands. Its MSB therefore has weight 1.
- R6: `rem` equals SA * 2^(Q_W-1) - SB * `quot`, and is always smaller than SB.
- R7: `sticky` is 1 exactly when `rem` is nonzero.
- R8: `exp_out` is the 13-bit two's-complement value effA - effB + 1023.
- R9: `sign_out` is the XOR of the operand sign bits (bit 63).
- R10: If B has a zero exponent field and a zero fraction, `dz` is 1 and `out_valid` rises one edge after acceptance. In that case `quot`, `rem`, `sticky` and `exp_out` are all zero, and `sign_out` still follows R9.
- R11: If A has a zero exponent field and a zero fraction and B is nonzero, the timing of R2 applies. `quot`, `rem`, `sticky` and `dz` are 0, and the effective exponent of A is taken as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `a_op`/`b_op` are offered |
| in_ready | output | 1 | Block is idle and takes operands |
| a_op | input | 64 | Dividend operand, binary64 |
| b_op | input | 64 | Divisor operand, binary64 |
| out_valid | output | 1 | Result outputs are valid (division done) |
| out_ready | input | 1 | Consumer takes the result |
| quot | output | 56 | Quotient bits, MSB weight 1 |
| rem | output | 53 | Final remainder |
| sticky | output | 1 | OR of the remainder bits |
| exp_out | output | 13 | Biased exponent difference, two's complement |
| sign_out | output | 1 | Result sign |
| dz | output | 1 | Divisor significand was zero |

## Verification
The assertions rely on the producer keeping `a_op` and `b_op` constant while `in_valid` waits for `in_ready`. The checks on quotient range and on the remainder bound also rely on that. The bench meets this by changing operands only after a transfer has been seen. The consumer is unconstrained: `out_ready` is driven with random stalls of any length, which exercises holding of the result. The operand mix includes random fields, forced zero exponents and both kinds of zero, so that every R4 path and both bypass cases are reached.

// File: rtl/dsig_pkg.sv
package dsig_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } dsig_state_e;
endpackage

// File: rtl/dsig_unpack.sv
module dsig_unpack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic [FRAC_W:0]       sig,
  output logic [EXP_W+1:0]      eff,
  output logic                  zero,
  output logic                  sgn
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int XE_W  = EXP_W + 2;
  localparam int LZ_W  = $clog2(SIG_W + 1);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac;
  logic              norm;
  logic [SIG_W-1:0]  raw;
  logic [LZ_W-1:0]   lz;
  logic              found;

  assign sgn   = op[EXP_W+FRAC_W];
  assign exp_f = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac  = op[FRAC_W-1:0];
  assign norm  = |exp_f;
  assign raw   = {norm, frac};
  assign zero  = !norm && !(|frac);

  // leading-zero count, highest set bit wins
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!found && raw[i]) begin
        lz    = LZ_W'(SIG_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign sig = raw << lz;
  assign eff = norm ? {2'b00, exp_f} : (XE_W'(1) - XE_W'(lz));
endmodule

// File: rtl/dsig_iter.sv
module dsig_iter #(
  parameter int SIG_W = 53,
  parameter int Q_W   = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SIG_W-1:0] dvd_in,
  input  logic [SIG_W-1:0] dvs_in,
  output logic [Q_W-1:0]   quot,
  output logic [SIG_W-1:0] remainder
);
  logic [SIG_W:0]   rem_q;
  logic [SIG_W-1:0] dvs_q;
  logic [Q_W-1:0]   quot_q;
  logic             ge;
  logic [SIG_W-1:0] diff;

  assign ge   = rem_q >= {1'b0, dvs_q};
  assign diff = ge ? SIG_W'(rem_q - {1'b0, dvs_q}) : rem_q[SIG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quot_q <= '0;
    end else if (load) begin
      rem_q  <= {1'b0, dvd_in};
      dvs_q  <= dvs_in;
      quot_q <= '0;
    end else if (step) begin
      rem_q  <= {diff, 1'b0};
      quot_q <= {quot_q[Q_W-2:0], ge};
    end
  end

  assign quot      = quot_q;
  assign remainder = rem_q[SIG_W:1];

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < {dvs_q, 1'b0}));

  // R6
  rem_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !rem_q[0]);
endmodule

// File: rtl/dsig_divider.sv
module dsig_divider #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int Q_W    = 56
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+FRAC_W:0]  a_op,
  input  logic [EXP_W+FRAC_W:0]  b_op,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [Q_W-1:0]         quot,
  output logic [FRAC_W:0]        rem,
  output logic                   sticky,
  output logic [EXP_W+1:0]       exp_out,
  output logic                   sign_out,
  output logic                   dz
);
  import dsig_pkg::*;

  localparam int SIG_W = FRAC_W + 1;
  localparam int XE_W  = EXP_W + 2;
  localparam int CNT_W = $clog2(Q_W + 1);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic [SIG_W-1:0] sig_a, sig_b;
  logic [XE_W-1:0]  eff_a, eff_b;
  logic             zero_a, zero_b, sgn_a, sgn_b;

  dsig_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .op(a_op), .sig(sig_a), .eff(eff_a), .zero(zero_a), .sgn(sgn_a));
  dsig_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .op(b_op), .sig(sig_b), .eff(eff_b), .zero(zero_b), .sgn(sgn_b));

  dsig_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dz_q, azero_q, sign_q;
  logic [XE_W-1:0]  exp_q;
  logic             accept;
  logic [Q_W-1:0]   quot_raw;
  logic [SIG_W-1:0] rem_raw;

  assign in_ready  = (state_q == S_IDLE);
  assign out_valid = (state_q == S_DONE);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      dz_q    <= 1'b0;
      azero_q <= 1'b0;
      sign_q  <= 1'b0;
      exp_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          dz_q    <= zero_b;
          azero_q <= zero_a;
          sign_q  <= sgn_a ^ sgn_b;
          exp_q   <= zero_b ? '0 : (eff_a - eff_b + XE_W'(BIAS));
          cnt_q   <= '0;
          state_q <= zero_b ? S_DONE : S_RUN;
        end
        S_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(Q_W - 1)) state_q <= S_DONE;
        end
        S_DONE: if (out_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  dsig_iter #(.SIG_W(SIG_W), .Q_W(Q_W)) u_iter (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .step(state_q == S_RUN),
    .dvd_in(sig_a), .dvs_in(sig_b),
    .quot(quot_raw), .remainder(rem_raw));

  assign quot     = dz_q ? '0 : quot_raw;
  assign rem      = dz_q ? '0 : rem_raw;
  assign sticky   = |rem;
  assign exp_out  = exp_q;
  assign sign_out = sign_q;
  assign dz       = dz_q;

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(quot) && $stable(rem)
                                   && $stable(exp_out) && $stable(sign_out) && $stable(dz)));

  // R2
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RUN && cnt_q == CNT_W'(Q_W - 1)) |=> out_valid);

  // R10
  dz_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_b) |=> (out_valid && dz));

  // R5
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dz && !azero_q) |-> (|quot[Q_W-1:Q_W-2]));

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid}));
endmodule

// File: tb/dsig_divider_tb.sv
module dsig_divider_tb;
  localparam int Q_W = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [63:0] a_op = '0, b_op = '0;
  logic in_ready, out_valid, sticky, sign_out, dz;
  logic [Q_W-1:0] quot;
  logic [52:0] rem;
  logic [12:0] exp_out;

  int checks = 0;
  int errors = 0;
  bit bp_en = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dsig_divider u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_op(a_op), .b_op(b_op), .out_valid(out_valid), .out_ready(out_ready),
    .quot(quot), .rem(rem), .sticky(sticky), .exp_out(exp_out),
    .sign_out(sign_out), .dz(dz));

  // behavioural reference
  int m_st = 0;
  int m_cnt = 0;
  logic [127:0] m_q, m_r;
  logic [12:0] m_e;
  bit m_s, m_dz, m_sub, m_az;

  task automatic unpack(input logic [63:0] op, output logic [52:0] sig, output int eff,
                        output bit sub);
    int e;
    e = int'(op[62:52]);
    sub = 1'b0;
    if (e != 0) begin
      sig = {1'b1, op[51:0]};
      eff = e;
    end else begin
      sig = {1'b0, op[51:0]};
      eff = 1;
      if (sig != 0) begin
        sub = 1'b1;
        while (!sig[52]) begin
          sig = sig << 1;
          eff = eff - 1;
        end
      end
    end
  endtask

  task automatic reference(input logic [63:0] a, input logic [63:0] b);
    logic [52:0] sa, sb;
    int ea, eb;
    bit suba, subb;
    logic [127:0] num;
    unpack(a, sa, ea, suba);
    unpack(b, sb, eb, subb);
    m_s   = a[63] ^ b[63];
    m_sub = suba || subb;
    m_az  = (sa == 0);
    m_dz  = (sb == 0);
    if (m_dz) begin
      m_q = '0; m_r = '0; m_e = '0;
    end else begin
      num = 128'(sa) << (Q_W - 1);
      m_q = num / 128'(sb);
      m_r = num % 128'(sb);
      m_e = 13'(ea - eb + 1023);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (in_valid) begin
          reference(a_op, b_op);
          if (m_dz) m_st = 2;
          else begin m_st = 1; m_cnt = Q_W; end
        end
        1: begin
          if (m_cnt == 1) m_st = 2;
          m_cnt = m_cnt - 1;
        end
        default: if (out_ready) m_st = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == (m_st == 0), "R1 in_ready", 128'(in_ready), 128'(m_st == 0));
      chk(out_valid == (m_st == 2), "R2 R3 out_valid", 128'(out_valid), 128'(m_st == 2));
      if (m_st == 2 && out_valid) begin
        chk(quot == m_q[Q_W-1:0],
            m_dz ? "R10 quot" : (m_az ? "R11 quot" : (m_sub ? "R4 R5 quot" : "R5 quot")),
            128'(quot), m_q);
        chk(rem == m_r[52:0], m_dz ? "R10 rem" : "R6 rem", 128'(rem), m_r);
        chk(sticky == (m_r != 0), "R7 sticky", 128'(sticky), 128'(m_r != 0));
        chk(exp_out == m_e, m_sub ? "R4 R8 exp" : "R8 exp", 128'(exp_out), 128'(m_e));
        chk(sign_out == m_s, "R9 sign", 128'(sign_out), 128'(m_s));
        chk(dz == m_dz, m_az ? "R11 dz" : "R10 dz", 128'(dz), 128'(m_dz));
      end
    end
  end

  always @(negedge clk) out_ready <= bp_en ? (($urandom % 4) == 0) : 1'b1;

  task automatic send(input logic [63:0] a, input logic [63:0] b);
    in_valid = 1'b1;
    a_op = a;
    b_op = b;
    forever begin
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (m_st != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] f);
    return {s, 11'(e), f};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk(in_ready == 1'b1, "R1 reset in_ready", 128'(in_ready), 128'(1));
    chk(out_valid == 1'b0, "R1 reset out_valid", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // directed cases
    send(mk(0, 1023, 52'h8000000000000), mk(0, 1023, 52'h0)); drain(); // 1.5/1
    send(mk(0, 1023, 52'h0), mk(0, 1024, 52'h8000000000000)); drain(); // 1/3
    send(mk(1, 1000, 52'h123456789abcd), mk(0, 1030, 52'hfffffffffffff)); drain(); // R9
    send(mk(0, 0, 52'h0000000000001), mk(0, 1023, 52'h0)); drain(); // R4 subnormal A
    send(mk(1, 2000, 52'h0), mk(1, 0, 52'h0800000000000)); drain(); // R4 subnormal B
    send(mk(0, 0, 52'h00000abcdef01), mk(0, 0, 52'h4000000000000)); drain(); // R4 both
    send(mk(0, 2047, 52'h0), mk(0, 1, 52'h0)); drain(); // R4 all-ones exponent
    send(mk(1, 0, 52'h0), mk(0, 1050, 52'h1234)); drain(); // R11 zero dividend
    send(mk(0, 1100, 52'h55), mk(1, 0, 52'h0)); drain(); // R10 zero divisor
    send(mk(0, 0, 52'h0), mk(0, 0, 52'h0)); drain(); // R10 both zero
    send(mk(0, 1023, 52'hfffffffffffff), mk(0, 1023, 52'hfffffffffffff)); drain(); // exact
    // back-to-back with in_valid offered immediately
    send(mk(0, 1023, 52'h1), mk(0, 1023, 52'h2));
    send(mk(0, 5, 52'h3), mk(1, 0, 52'h0));
    send(mk(1, 700, 52'h777), mk(1, 900, 52'h999));
    drain();
    // R3 random back-pressure with random operands
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 5 == 1) a[62:52] = '0;
      if (i % 7 == 2) b[62:52] = '0;
      if (i % 11 == 3) b[62:0] = '0;
      if (i % 13 == 4) a[62:0] = '0;
      send(a, b);
    end
    drain();
    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule